// File: doc/BRIEF.md
# Two-Coin Drink Dispenser Controller with Jam Lockout

This block sequences a drink dispenser that charges a fixed number of coins (two by default). It counts coin pulses, waits for one of several product selections, and emits a one-cycle dispense strobe for the chosen product. It then holds until the bottle-taken pulse arrives. A jam-detected pulse takes priority over everything else. It discards any credit and parks the machine in a lockout state. In that state coins are refused and nothing is dispensed until a jam-cleared pulse returns the machine to idle.

Every input is a synchronous single-cycle pulse, sampled on the rising clock edge. Every output is registered. The block carries no data stream, so it has no valid/ready handshake and exerts no back-pressure. The coin-accept enable tells the coin mechanism when a coin will be counted. A coin pulse that arrives while the enable is low is dropped. The status code exposes the controller state to the surrounding logic.

Top module: `vend_ctrl`

## Requirements
- R1: After reset, status is 0 (idle), coin_en_o is 1 and disp_o is all zero.
- R2: Each coin pulse seen in idle (status 0) or collecting (status 1) adds one credit. The machine shows status 1 until PRICE credits are reached, then status 2 (paid) on the next cycle.
- R3: In paid, a selection sets bit k of disp_o for exactly one cycle, in the cycle the status turns to 3 (vending). Here k is the lowest-numbered asserted bit of sel_i.
- R4: Selection pulses in idle or collecting change neither the status nor disp_o.
- R5: In vending, taken_i returns the machine to idle. taken_i has no effect in any other state.
- R6: jam_i in any state moves the machine to status 4 (stuck) on the next cycle and discards all credit. A jam in the same cycle as a selection dispenses nothing.
- R7: In stuck, coins and selections are ignored. clr_i returns the machine to idle, but jam_i in the same cycle as clr_i keeps it stuck.
- R8: coin_en_o is 1 only in status 0 and 1. Coin pulses in paid or vending leave the status unchanged.
- R9: disp_o has at most one bit set, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coin_i | input | 1 | One valid coin inserted (pulse) |
| sel_i | input | NPROD | Product selection pulses, bit k = product k |
| taken_i | input | 1 | Bottle removed from the chute (pulse) |
| jam_i | input | 1 | Jam detected (pulse) |
| clr_i | input | 1 | Jam cleared (pulse) |
| disp_o | output | NPROD | Dispense strobe for product k, one cycle |
| coin_en_o | output | 1 | Coin mechanism may accept a coin |
| status_o | output | 3 | 0 idle, 1 collecting, 2 paid, 3 vending, 4 stuck |

## Verification
Plain purchases are run for each product, which shows that each selection reaches its own strobe. Selections with two or three bits set show that the lowest index wins. Stray selections, taken pulses and surplus coins are then injected in states where they must do nothing, which separates real state guards from a machine that moves on any pulse. Jams are raised in every state, together with a selection, and together with a clear. Credit loss is shown by needing two fresh coins after the lockout, and jam-over-clear priority is shown by staying stuck.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_PAID    = 3'd2,
    ST_VEND    = 3'd3,
    ST_STUCK   = 3'd4
  } vend_state_t;
endpackage

// File: rtl/vend_credit.sv
module vend_credit #(
  parameter int PRICE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic last
);
  localparam int CW = (PRICE < 2) ? 1 : $clog2(PRICE);
  localparam logic [CW-1:0] LAST_VAL = CW'(PRICE - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (inc)    count <= count + 1'b1;
  end

  assign last = (count == LAST_VAL);
endmodule

// File: rtl/vend_sel_pick.sv
module vend_sel_pick #(
  parameter int NPROD = 3
) (
  input  logic [NPROD-1:0] req,
  output logic [NPROD-1:0] grant
);
  logic [NPROD:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NPROD; i++) begin : g_pick
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
#(
  parameter int NPROD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coin,
  input  logic [NPROD-1:0] grant,
  input  logic             taken,
  input  logic             jam,
  input  logic             clr,
  input  logic             cred_last,
  output logic             cred_inc,
  output logic             cred_clr,
  output vend_state_t      state,
  output logic [NPROD-1:0] disp
);
  vend_state_t      nxt;
  logic [NPROD-1:0] disp_n;

  always_comb begin
    nxt      = state;
    disp_n   = '0;
    cred_inc = 1'b0;
    cred_clr = 1'b0;
    if (jam) begin
      nxt      = ST_STUCK;
      cred_clr = 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_COLLECT: begin
          if (coin) begin
            if (cred_last) begin
              nxt      = ST_PAID;
              cred_clr = 1'b1;
            end else begin
              nxt      = ST_COLLECT;
              cred_inc = 1'b1;
            end
          end
        end
        ST_PAID: begin
          if (|grant) begin
            nxt    = ST_VEND;
            disp_n = grant;
          end
        end
        ST_VEND:  if (taken) nxt = ST_IDLE;
        ST_STUCK: if (clr)   nxt = ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      disp  <= '0;
    end else begin
      state <= nxt;
      disp  <= disp_n;
    end
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int NPROD = 3,
  parameter int PRICE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coin_i,
  input  logic [NPROD-1:0] sel_i,
  input  logic             taken_i,
  input  logic             jam_i,
  input  logic             clr_i,
  output logic [NPROD-1:0] disp_o,
  output logic             coin_en_o,
  output logic [2:0]       status_o
);
  logic [NPROD-1:0] grant;
  logic             cred_last, cred_inc, cred_clr;
  vend_state_t      state;

  vend_sel_pick #(.NPROD(NPROD)) u_pick (
    .req   (sel_i),
    .grant (grant)
  );

  vend_credit #(.PRICE(PRICE)) u_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cred_inc),
    .clr   (cred_clr),
    .last  (cred_last)
  );

  vend_fsm #(.NPROD(NPROD)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .coin      (coin_i),
    .grant     (grant),
    .taken     (taken_i),
    .jam       (jam_i),
    .clr       (clr_i),
    .cred_last (cred_last),
    .cred_inc  (cred_inc),
    .cred_clr  (cred_clr),
    .state     (state),
    .disp      (disp_o)
  );

  assign status_o  = state;
  assign coin_en_o = (state == ST_IDLE) || (state == ST_COLLECT);
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int NPROD = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coin_i,
  input logic [NPROD-1:0] sel_i,
  input logic             taken_i,
  input logic             jam_i,
  input logic             clr_i,
  input logic [NPROD-1:0] disp_o,
  input logic             coin_en_o,
  input logic [2:0]       status_o
);
  AST_JAM_TO_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    jam_i |=> status_o == 3'd4); // R6
  AST_DISP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_o)); // R9
  AST_DISP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_o) |=> disp_o == '0); // R9
  AST_DISP_IN_VEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_o) |-> status_o == 3'd3); // R3
  AST_TAKEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'd3 && taken_i && !jam_i) |=> status_o == 3'd0); // R5
  AST_STUCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'd4 && !clr_i) |=> status_o == 3'd4); // R7
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'd4 && clr_i && !jam_i) |=> status_o == 3'd0); // R7
  AST_IDLE_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'd0 && !coin_i && !jam_i) |=> status_o == 3'd0 && disp_o == '0); // R4
  AST_COIN_EN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    coin_en_o == (status_o <= 3'd1)); // R8
  AST_PAID_COIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'd2 && sel_i == '0 && !jam_i) |=> status_o == 3'd2); // R8
endmodule

bind vend_ctrl vend_ctrl_chk #(.NPROD(NPROD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .coin_i    (coin_i),
  .sel_i     (sel_i),
  .taken_i   (taken_i),
  .jam_i     (jam_i),
  .clr_i     (clr_i),
  .disp_o    (disp_o),
  .coin_en_o (coin_en_o),
  .status_o  (status_o)
);

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
  localparam int NPROD = 3;
  localparam int PRICE = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             coin_i = 1'b0;
  logic [NPROD-1:0] sel_i = '0;
  logic             taken_i = 1'b0;
  logic             jam_i = 1'b0;
  logic             clr_i = 1'b0;
  logic [NPROD-1:0] disp_o;
  logic             coin_en_o;
  logic [2:0]       status_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_st = 0;
  int m_cred = 0;
  int m_disp = 0;

  always #4 clk = ~clk;

  vend_ctrl #(.NPROD(NPROD), .PRICE(PRICE)) u0 (
    .clk(clk), .rst_n(rst_n), .coin_i(coin_i), .sel_i(sel_i),
    .taken_i(taken_i), .jam_i(jam_i), .clr_i(clr_i),
    .disp_o(disp_o), .coin_en_o(coin_en_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    int d;
    d = 0;
    if (jam_i) begin
      m_st = 4; m_cred = 0;
    end else begin
      case (m_st)
        0, 1: if (coin_i) begin
          m_cred++;
          if (m_cred >= PRICE) begin m_st = 2; m_cred = 0; end
          else m_st = 1;
        end
        2: if (sel_i != 0) begin
          m_st = 3;
          for (int k = NPROD - 1; k >= 0; k--) if (sel_i[k]) d = 1 << k;
        end
        3: if (taken_i) m_st = 0;
        4: if (clr_i) m_st = 0;
        default: m_st = 0;
      endcase
    end
    m_disp = d;
  endtask

  task automatic cycle(input bit c, input int s, input bit t, input bit j, input bit cl, input string tag);
    coin_i = c; sel_i = NPROD'(s); taken_i = t; jam_i = j; clr_i = cl;
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
    coin_i = 0; sel_i = '0; taken_i = 0; jam_i = 0; clr_i = 0;
    chk(tag, int'(status_o), m_st, "status");
    chk(tag, int'(disp_o), m_disp, "disp");
    chk(tag, int'(coin_en_o), (m_st <= 1) ? 1 : 0, "coin_en");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", int'(status_o), 0, "status");
    chk("R1", int'(disp_o), 0, "disp");
    chk("R1", int'(coin_en_o), 1, "coin_en");

    // plain purchases of each product
    for (int p = 0; p < NPROD; p++) begin
      cycle(1, 0, 0, 0, 0, "R2");
      cycle(1, 0, 0, 0, 0, "R2");
      cycle(0, 1 << p, 0, 0, 0, "R3");
      idle(2, "R9");
      cycle(0, 0, 1, 0, 0, "R5");
    end
    // lowest selection wins
    cycle(1, 0, 0, 0, 0, "R2"); cycle(1, 0, 0, 0, 0, "R2");
    cycle(0, 3'b110, 0, 0, 0, "R3");
    cycle(0, 3'b111, 0, 0, 0, "R9");
    cycle(1, 0, 0, 0, 0, "R8");
    cycle(0, 0, 1, 0, 0, "R5");
    // stray selections and taken in idle / collecting
    cycle(0, 3'b001, 0, 0, 0, "R4");
    cycle(0, 0, 1, 0, 0, "R5");
    cycle(1, 0, 0, 0, 0, "R2");
    cycle(0, 3'b100, 0, 0, 0, "R4");
    cycle(0, 0, 1, 0, 0, "R5");
    cycle(1, 0, 0, 0, 0, "R2");
    // extra coins in paid are ignored
    cycle(1, 0, 0, 0, 0, "R8");
    cycle(0, 0, 1, 0, 0, "R5");
    cycle(0, 3'b100, 0, 0, 0, "R3");
    cycle(0, 0, 1, 0, 0, "R5");
    // jam in collecting loses credit, lockout behaviour
    cycle(1, 0, 0, 0, 0, "R2");
    cycle(0, 0, 0, 1, 0, "R6");
    cycle(1, 3'b001, 1, 0, 0, "R7");
    cycle(0, 0, 0, 1, 1, "R7");
    cycle(0, 0, 0, 0, 1, "R7");
    cycle(1, 0, 0, 0, 0, "R6");
    idle(1, "R6");
    cycle(1, 0, 0, 0, 0, "R6");
    // jam together with selection in paid
    cycle(0, 3'b010, 0, 1, 0, "R6");
    cycle(0, 0, 0, 0, 1, "R7");
    // jam in vending and in idle
    cycle(1, 0, 0, 0, 0, "R2"); cycle(1, 0, 0, 0, 0, "R2");
    cycle(0, 3'b001, 0, 0, 0, "R3");
    cycle(0, 0, 1, 1, 0, "R6");
    cycle(0, 0, 0, 0, 1, "R7");
    cycle(0, 0, 0, 1, 0, "R6");
    cycle(0, 0, 0, 1, 0, "R6");
    cycle(0, 0, 0, 0, 1, "R7");
    idle(2, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule